// File: doc/BRIEF.md
# Breakpoint Trigger Comparator

This block keeps a small bank of breakpoint triggers and compares every instruction fetch and every load or store against them. Each trigger has a 64-bit control word and a 64-bit compare value. For each access the unit is given the address, the data, the access kind and the current privilege level. Every trigger applies its own compare mode, its privilege filter and its access-kind filter. Triggers can be linked into chains, and a chain counts only when all of its members match. When a trigger or chain hits, the unit reports the index and the action to take: a breakpoint exception or entry to debug mode.

Software reaches the triggers through a small write port and a set of read outputs. A select register chooses the trigger that control and compare writes land on and that the read outputs show. Control writes are legalized as they are stored. A machine-mode enable bit, with a saved copy, gates triggers while the hart runs in machine mode. Trap entry and trap return update that bit and its copy.

Top module: `trig_match_unit`

## Requirements
- R1: After reset the select register is 0, every control word reads 0xF000_0000_0000_0000, every compare value is 0, both enable bits are 0 and no hit is reported.
- R2: A write to the select register (wr_addr 0) with a full 64-bit value at or above NUM_TRIG leaves the select register unchanged. A smaller value is stored.
- R3: A control write (wr_addr 1) whose type field [63:60] is not 2 stores 0xF000_0000_0000_0000. In that state the trigger never matches.
- R4: In a stored type-2 control word, the compare mode [10:7] becomes 0 unless it was 0, 2 or 3. The select bit 19 is kept only if the execute bit 2 is also set. Bits [58:20], [18:16] and 5 read 0. The privilege bits M (6), S (4) and U (3) and the kind bits EXECUTE (2), STORE (1) and LOAD (0) are kept as written.
- R5: The dmode bit 59 is stored only while debug_mode is high. The action field [15:12] keeps 1 (enter debug mode) only when the stored dmode is 1. It keeps 0 (breakpoint exception) always. Any other action becomes 0.
- R6: Mode 0 matches when the compared value equals the compare value (wr_addr 2). Mode 2 matches on unsigned greater-or-equal and mode 3 on unsigned less-than. The compared value is acc_data when the select bit is set and acc_addr otherwise.
- R7: A trigger matches only if its privilege bit for acc_priv is set (0 = U, 1 = S, 3 = M; the value 2 never matches). It must also have the kind bit for acc_kind set (0 = execute, 1 = load, 2 = store).
- R8: The chain bit 11 of trigger i joins it to trigger i+1. A chain hits only when every member matches on the same access. The chain bit is stored only while chainable is high.
- R9: If more than MAX_CHAIN consecutive triggers have their chain bit set, no trigger hits.
- R10: In machine mode a trigger matches only when mte is 1. A write to wr_addr 3 loads mte from bit 3 and mpte from bit 7. trap_enter_m copies mte to mpte and clears mte. ret_from_m copies mpte to mte. A trap takes precedence over a return, and both take precedence over a write.
- R11: No trigger hits while debug_mode is high.
- R12: A hit sets hit_valid for exactly one cycle, on the cycle after the access. When several groups hit, the group with the lowest-numbered first member wins. hit_idx reports that first member, and hit_debug reports its action bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 select, 1 control, 2 compare, 3 enable bits |
| wr_data | input | 64 | Write data |
| chainable | input | 1 | Allows the chain bit to be stored |
| debug_mode | input | 1 | Hart is in debug mode |
| trap_enter_m | input | 1 | Trap into machine mode this cycle |
| ret_from_m | input | 1 | Return from machine mode this cycle |
| acc_valid | input | 1 | Access presented this cycle |
| acc_kind | input | 2 | 0 execute, 1 load, 2 store |
| acc_addr | input | 64 | Access address |
| acc_data | input | 64 | Access data or instruction |
| acc_priv | input | 2 | Privilege: 0 U, 1 S, 3 M |
| rd_sel | output | SEL_W | Select register |
| rd_ctrl | output | 64 | Control word of the selected trigger |
| rd_cmp | output | 64 | Compare value of the selected trigger |
| mte | output | 1 | Machine-mode trigger enable |
| mpte | output | 1 | Saved machine-mode trigger enable |
| hit_valid | output | 1 | One-cycle hit pulse |
| hit_idx | output | SEL_W | First trigger of the winning group |
| hit_debug | output | 1 | 1 enter debug mode, 0 breakpoint exception |

## Verification
Each compare mode is driven with values on both sides of its boundary and at the extremes of the unsigned range. These show whether equal, greater-or-equal and less-than are told apart and whether the compare is unsigned. Accesses are repeated across the privilege levels and the three access kinds, so that each filter bit is shown to block on its own. Chain tests place one member inside and one outside its range, which separates a chain from its members acting alone. A run of three chain bits is compared with a run of two to show where the length limit applies. Overlapping triggers with different actions show which group wins and that its action is the one reported.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int WORD_W = 64;

  localparam logic [3:0] TYPE_ADDR = 4'd2;
  localparam logic [3:0] TYPE_OFF  = 4'd15;

  localparam logic [3:0] MODE_EQ = 4'd0;
  localparam logic [3:0] MODE_GE = 4'd2;
  localparam logic [3:0] MODE_LT = 4'd3;

  localparam logic [3:0] ACT_BRK = 4'd0;
  localparam logic [3:0] ACT_DBG = 4'd1;

  typedef enum logic [1:0] {
    ACC_EXEC  = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_kind_e;

  typedef struct packed {
    logic [3:0] typ;
    logic       sel;
    logic [3:0] mode;
    logic       en_m;
    logic       en_s;
    logic       en_u;
    logic       en_x;
    logic       en_st;
    logic       en_ld;
  } lane_cfg_t;

  // Legal form of a control word as it will be stored.
  function automatic logic [WORD_W-1:0] legalize_ctrl(input logic [WORD_W-1:0] w,
                                                      input logic dbg,
                                                      input logic chn);
    logic [WORD_W-1:0] r;
    logic              dm;
    r  = w;
    dm = w[59] & dbg;
    if (w[63:60] != TYPE_ADDR) begin
      r = {TYPE_OFF, 60'd0};
    end else begin
      r[59]    = dm;
      r[58:20] = '0;
      r[19]    = w[19] & w[2];
      r[18:16] = '0;
      r[15:12] = ((w[15:12] == ACT_BRK) || (w[15:12] == ACT_DBG && dm)) ? w[15:12] : ACT_BRK;
      r[11]    = w[11] & chn;
      r[10:7]  = (w[10:7] == MODE_GE || w[10:7] == MODE_LT) ? w[10:7] : MODE_EQ;
      r[5]     = 1'b0;
    end
    return r;
  endfunction

  // Unsigned comparison selected by the compare mode.
  function automatic logic cmp_hit(input logic [3:0] mode,
                                   input logic [WORD_W-1:0] v,
                                   input logic [WORD_W-1:0] ref_v);
    case (mode)
      MODE_GE: return v >= ref_v;
      MODE_LT: return v <  ref_v;
      default: return v == ref_v;
    endcase
  endfunction
endpackage

// File: rtl/trig_regs.sv
module trig_regs
  import trig_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              chainable,
  input  logic              debug_mode,
  input  logic              trap_enter_m,
  input  logic              ret_from_m,
  output logic [SEL_W-1:0]  sel_q,
  output logic [WORD_W-1:0] ctrl_q [NUM_TRIG],
  output logic [WORD_W-1:0] cmp_q  [NUM_TRIG],
  output logic              mte_q,
  output logic              mpte_q
);
  localparam logic [WORD_W-1:0] NUM_W    = WORD_W'(NUM_TRIG);
  localparam logic [WORD_W-1:0] CTRL_RST = {TYPE_OFF, 60'd0};

  logic sel_wr_ok;
  assign sel_wr_ok = wr_en && (wr_addr == 2'd0) && (wr_data < NUM_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int i = 0; i < NUM_TRIG; i++) begin
        ctrl_q[i] <= CTRL_RST;
        cmp_q[i]  <= '0;
      end
    end else begin
      if (sel_wr_ok) sel_q <= wr_data[SEL_W-1:0];
      if (wr_en && wr_addr == 2'd1) ctrl_q[sel_q] <= legalize_ctrl(wr_data, debug_mode, chainable);
      if (wr_en && wr_addr == 2'd2) cmp_q[sel_q] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mte_q  <= 1'b0;
      mpte_q <= 1'b0;
    end else if (trap_enter_m) begin
      mpte_q <= mte_q;
      mte_q  <= 1'b0;
    end else if (ret_from_m) begin
      mte_q  <= mpte_q;
    end else if (wr_en && wr_addr == 2'd3) begin
      mte_q  <= wr_data[3];
      mpte_q <= wr_data[7];
    end
  end

  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) WORD_W'(sel_q) < NUM_W); // R2
  AST_TRAP_SAVES_MTE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter_m |=> (!mte_q && mpte_q == $past(mte_q))); // R10
  AST_RET_RESTORES_MTE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_from_m && !trap_enter_m) |=> (mte_q == $past(mpte_q))); // R10

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_type_chk
    AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[g][63:60] == TYPE_ADDR) || (ctrl_q[g][63:60] == TYPE_OFF)); // R3
  end
endmodule

// File: rtl/trig_lane.sv
module trig_lane
  import trig_pkg::*;
(
  input  lane_cfg_t         cfg,
  input  logic [WORD_W-1:0] cmp_val,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [WORD_W-1:0] acc_addr,
  input  logic [WORD_W-1:0] acc_data,
  input  logic [1:0]        acc_priv,
  input  logic              mte,
  input  logic              debug_mode,
  output logic              matched
);
  logic              kind_ok;
  logic              priv_ok;
  logic [WORD_W-1:0] probe;

  always_comb begin
    case (acc_kind)
      ACC_EXEC:  kind_ok = cfg.en_x;
      ACC_LOAD:  kind_ok = cfg.en_ld;
      ACC_STORE: kind_ok = cfg.en_st;
      default:   kind_ok = 1'b0;
    endcase
    case (acc_priv)
      2'd0:    priv_ok = cfg.en_u;
      2'd1:    priv_ok = cfg.en_s;
      2'd3:    priv_ok = cfg.en_m & mte;
      default: priv_ok = 1'b0;
    endcase
    probe   = cfg.sel ? acc_data : acc_addr;
    matched = acc_valid && !debug_mode && (cfg.typ == TYPE_ADDR) && kind_ok && priv_ok
              && cmp_hit(cfg.mode, probe, cmp_val);
  end
endmodule

// File: rtl/trig_chain.sv
module trig_chain #(
  parameter int NUM_TRIG  = 4,
  parameter int MAX_CHAIN = 2,
  parameter int SEL_W     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] matched,
  input  logic [NUM_TRIG-1:0] chain,
  input  logic [NUM_TRIG-1:0] act_dbg,
  input  logic [NUM_TRIG-1:0] dmode,
  output logic                fire_any,
  output logic [SEL_W-1:0]    win_idx,
  output logic                win_act,
  output logic                chain_illegal
);
  logic [NUM_TRIG-1:0] fire;
  logic [SEL_W-1:0]    head_of [NUM_TRIG];
  logic                win_dmode;

  always_comb begin
    logic            prev_chain;
    logic            ok;
    logic [SEL_W-1:0] hd;
    int              run;
    prev_chain    = 1'b0;
    ok            = 1'b0;
    hd            = '0;
    run           = 0;
    chain_illegal = 1'b0;
    fire          = '0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (!prev_chain) hd = SEL_W'(i);
      ok         = matched[i] & (!prev_chain | ok);
      head_of[i] = hd;
      fire[i]    = ok & ((i == NUM_TRIG - 1) | !chain[i]);
      run        = chain[i] ? run + 1 : 0;
      if (run > MAX_CHAIN) chain_illegal = 1'b1;
      prev_chain = chain[i];
    end
  end

  always_comb begin
    fire_any  = 1'b0;
    win_idx   = '0;
    for (int i = NUM_TRIG - 1; i >= 0; i--) begin
      if (fire[i] && !chain_illegal) begin
        fire_any = 1'b1;
        win_idx  = head_of[i];
      end
    end
    win_act   = act_dbg[win_idx];
    win_dmode = dmode[win_idx];
  end

  AST_ILLEGAL_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    chain_illegal |-> !fire_any); // R9
  AST_DEBUG_ACT_DMODE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_any && win_act) |-> win_dmode); // R5
endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import trig_pkg::*;
#(
  parameter int NUM_TRIG  = 4,
  parameter int MAX_CHAIN = 2,
  localparam int SEL_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [63:0]       wr_data,
  input  logic              chainable,
  input  logic              debug_mode,
  input  logic              trap_enter_m,
  input  logic              ret_from_m,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [63:0]       acc_addr,
  input  logic [63:0]       acc_data,
  input  logic [1:0]        acc_priv,
  output logic [SEL_W-1:0]  rd_sel,
  output logic [63:0]       rd_ctrl,
  output logic [63:0]       rd_cmp,
  output logic              mte,
  output logic              mpte,
  output logic              hit_valid,
  output logic [SEL_W-1:0]  hit_idx,
  output logic              hit_debug
);
  logic [WORD_W-1:0]   ctrl_q [NUM_TRIG];
  logic [WORD_W-1:0]   cmp_q  [NUM_TRIG];
  logic [SEL_W-1:0]    sel_q;
  logic                mte_q, mpte_q;
  logic [NUM_TRIG-1:0] matched, chain_bits, act_bits, dmode_bits;
  logic                fire_any, win_act, chain_illegal;
  logic [SEL_W-1:0]    win_idx;

  trig_regs #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .chainable(chainable), .debug_mode(debug_mode), .trap_enter_m(trap_enter_m),
    .ret_from_m(ret_from_m), .sel_q(sel_q), .ctrl_q(ctrl_q), .cmp_q(cmp_q),
    .mte_q(mte_q), .mpte_q(mpte_q)
  );

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_lane
    lane_cfg_t cfg;
    assign cfg = '{typ: ctrl_q[g][63:60], sel: ctrl_q[g][19], mode: ctrl_q[g][10:7],
                   en_m: ctrl_q[g][6], en_s: ctrl_q[g][4], en_u: ctrl_q[g][3],
                   en_x: ctrl_q[g][2], en_st: ctrl_q[g][1], en_ld: ctrl_q[g][0]};
    assign chain_bits[g] = ctrl_q[g][11];
    assign act_bits[g]   = ctrl_q[g][12];
    assign dmode_bits[g] = ctrl_q[g][59];
    trig_lane u_lane (
      .cfg(cfg), .cmp_val(cmp_q[g]), .acc_valid(acc_valid), .acc_kind(acc_kind),
      .acc_addr(acc_addr), .acc_data(acc_data), .acc_priv(acc_priv), .mte(mte_q),
      .debug_mode(debug_mode), .matched(matched[g])
    );
  end

  trig_chain #(.NUM_TRIG(NUM_TRIG), .MAX_CHAIN(MAX_CHAIN), .SEL_W(SEL_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .matched(matched), .chain(chain_bits), .act_dbg(act_bits),
    .dmode(dmode_bits), .fire_any(fire_any), .win_idx(win_idx), .win_act(win_act),
    .chain_illegal(chain_illegal)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit_idx   <= '0;
      hit_debug <= 1'b0;
    end else begin
      hit_valid <= fire_any;
      hit_idx   <= fire_any ? win_idx : '0;
      hit_debug <= fire_any & win_act;
    end
  end

  assign rd_sel  = sel_q;
  assign rd_ctrl = ctrl_q[sel_q];
  assign rd_cmp  = cmp_q[sel_q];
  assign mte     = mte_q;
  assign mpte    = mpte_q;

  AST_NO_HIT_IN_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    debug_mode |=> !hit_valid); // R11
  AST_HIT_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> $past(acc_valid)); // R12
endmodule

// File: tb/trig_match_unit_tb.sv
`timescale 1ns/1ps
module trig_match_unit_tb;
  localparam int NT = 4;
  localparam logic [63:0] OFF = 64'hF000_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, chainable = 1, debug_mode = 0, trap_enter_m = 0, ret_from_m = 0, acc_valid = 0;
  logic [1:0] wr_addr = 0, acc_kind = 0, acc_priv = 0;
  logic [63:0] wr_data = 0, acc_addr = 0, acc_data = 0;
  logic [1:0] rd_sel, hit_idx;
  logic [63:0] rd_ctrl, rd_cmp;
  logic mte, mpte, hit_valid, hit_debug;
  logic g_hit, g_dbg;
  logic [1:0] g_idx;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  trig_match_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .chainable(chainable), .debug_mode(debug_mode), .trap_enter_m(trap_enter_m),
    .ret_from_m(ret_from_m), .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .acc_data(acc_data), .acc_priv(acc_priv), .rd_sel(rd_sel), .rd_ctrl(rd_ctrl),
    .rd_cmp(rd_cmp), .mte(mte), .mpte(mpte), .hit_valid(hit_valid), .hit_idx(hit_idx),
    .hit_debug(hit_debug)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [3:0] typ, input logic dm, input logic [3:0] act,
                                     input logic ch, input logic [3:0] mt, input logic m,
                                     input logic s, input logic u, input logic x,
                                     input logic st, input logic ld, input logic sl);
    logic [63:0] w;
    w = '0;
    w[63:60] = typ; w[59] = dm; w[19] = sl; w[15:12] = act; w[11] = ch; w[10:7] = mt;
    w[6] = m; w[4] = s; w[3] = u; w[2] = x; w[1] = st; w[0] = ld;
    return w;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic setup(input int i, input logic [63:0] c, input logic [63:0] v);
    wr(0, 64'(i)); wr(1, c); wr(2, v);
  endtask

  task automatic clear_all();
    for (int i = 0; i < NT; i++) begin wr(0, 64'(i)); wr(1, 64'd0); end
  endtask

  task automatic acc(input logic [1:0] k, input logic [63:0] a, input logic [63:0] d, input logic [1:0] p);
    @(negedge clk); acc_valid = 1; acc_kind = k; acc_addr = a; acc_data = d; acc_priv = p;
    @(negedge clk); acc_valid = 0;
    g_hit = hit_valid; g_idx = hit_idx; g_dbg = hit_debug;
  endtask

  // trigger helpers: load-only, U-mode
  function automatic logic [63:0] ldu(input logic [3:0] mt, input logic ch);
    return mk(4'd2, 0, 0, ch, mt, 0, 0, 1, 0, 0, 1, 0);
  endfunction

  task automatic t_reset();
    chk("R1 sel", 64'(rd_sel), 0);
    chk("R1 ctrl", rd_ctrl, OFF);
    chk("R1 cmp", rd_cmp, 0);
    chk("R1 mte", {62'd0, mpte, mte}, 0);
    chk("R1 hit", 64'(hit_valid), 0);
    wr(0, 64'd3);
    chk("R1 ctrl3", rd_ctrl, OFF);
    acc(1, 64'd0, 64'd0, 0);
    chk("R1 no hit from off trigger", 64'(g_hit), 0);
  endtask

  task automatic t_select();
    wr(0, 64'd1);
    chk("R2 sel store", 64'(rd_sel), 1);
    wr(0, 64'd4);
    chk("R2 sel ignore 4", 64'(rd_sel), 1);
    wr(0, 64'h1_0000_0002);
    chk("R2 sel ignore wide", 64'(rd_sel), 1);
  endtask

  task automatic t_type();
    wr(0, 64'd0);
    wr(1, mk(4'd3, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 0));
    chk("R3 type forced off", rd_ctrl, OFF);
    wr(1, mk(4'd6, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 0));
    chk("R3 type6 forced off", rd_ctrl, OFF);
    wr(2, 64'd0);
    acc(1, 64'd0, 64'd0, 0);
    chk("R3 off never matches", 64'(g_hit), 0);
  endtask

  task automatic t_legal();
    wr(0, 64'd0);
    wr(1, mk(4'd2, 0, 0, 0, 4'd5, 1, 0, 0, 0, 0, 1, 1) | (64'd1 << 20) | (64'd1 << 16) | (64'd1 << 40) | (64'd1 << 5));
    chk("R4 cleanup", rd_ctrl, mk(4'd2, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0));
    wr(1, mk(4'd2, 0, 0, 0, 4'd3, 0, 1, 1, 1, 1, 0, 1));
    chk("R4 keep select+lt", rd_ctrl, mk(4'd2, 0, 0, 0, 4'd3, 0, 1, 1, 1, 1, 0, 1));
  endtask

  task automatic t_action();
    wr(0, 64'd0);
    wr(1, mk(4'd2, 1, 1, 0, 0, 0, 0, 1, 0, 0, 1, 0));
    chk("R5 no dmode outside debug", rd_ctrl, mk(4'd2, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0));
    debug_mode = 1;
    wr(1, mk(4'd2, 1, 1, 0, 0, 0, 0, 1, 0, 0, 1, 0));
    chk("R5 dmode action kept", rd_ctrl, mk(4'd2, 1, 1, 0, 0, 0, 0, 1, 0, 0, 1, 0));
    wr(1, mk(4'd2, 1, 4'd4, 0, 0, 0, 0, 1, 0, 0, 1, 0));
    chk("R5 action 4 forced", rd_ctrl, mk(4'd2, 1, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0));
    debug_mode = 0;
    clear_all();
  endtask

  task automatic t_compare();
    setup(0, ldu(4'd0, 0), 64'h1000);
    acc(1, 64'h1000, 0, 0); chk("R6 eq hit", {61'd0, g_hit, g_idx}, {61'd0, 1'b1, 2'd0});
    chk("R6 eq action brk", 64'(g_dbg), 0);
    acc(1, 64'h1008, 0, 0); chk("R6 eq miss", 64'(g_hit), 0);
    wr(1, ldu(4'd2, 0));
    acc(1, 64'h1000, 0, 0); chk("R6 ge edge", 64'(g_hit), 1);
    acc(1, 64'h0FFF, 0, 0); chk("R6 ge below", 64'(g_hit), 0);
    wr(1, ldu(4'd3, 0));
    acc(1, 64'h0FFF, 0, 0); chk("R6 lt hit", 64'(g_hit), 1);
    acc(1, 64'h1000, 0, 0); chk("R6 lt edge", 64'(g_hit), 0);
    acc(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0); chk("R6 lt unsigned", 64'(g_hit), 0);
    setup(0, mk(4'd2, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 1), 64'hDEAD);
    acc(0, 64'h1234, 64'hDEAD, 0); chk("R6 select data hit", 64'(g_hit), 1);
    acc(0, 64'hDEAD, 64'h0, 0); chk("R6 select ignores addr", 64'(g_hit), 0);
    clear_all();
  endtask

  task automatic t_filter();
    setup(0, ldu(4'd0, 0), 64'h40);
    acc(1, 64'h40, 0, 1); chk("R7 S blocked", 64'(g_hit), 0);
    acc(1, 64'h40, 0, 2); chk("R7 priv2 blocked", 64'(g_hit), 0);
    acc(2, 64'h40, 0, 0); chk("R7 store blocked", 64'(g_hit), 0);
    acc(0, 64'h40, 0, 0); chk("R7 exec blocked", 64'(g_hit), 0);
    acc(1, 64'h40, 0, 0); chk("R7 load U hit", 64'(g_hit), 1);
    clear_all();
  endtask

  task automatic t_chain();
    chainable = 1;
    setup(0, ldu(4'd2, 1), 64'h100);
    chk("R8 chain bit kept", 64'(rd_ctrl[11]), 1);
    setup(1, ldu(4'd3, 0), 64'h200);
    acc(1, 64'h180, 0, 0); chk("R8 chain both", {61'd0, g_hit, g_idx}, {61'd0, 1'b1, 2'd0});
    acc(1, 64'h80, 0, 0);  chk("R8 head fails", 64'(g_hit), 0);
    acc(1, 64'h280, 0, 0); chk("R8 tail fails", 64'(g_hit), 0);
    chainable = 0;
    setup(0, ldu(4'd2, 1), 64'h100);
    chk("R8 chain bit dropped", 64'(rd_ctrl[11]), 0);
    acc(1, 64'h80, 0, 0); chk("R8 unchained tail alone", {61'd0, g_hit, g_idx}, {61'd0, 1'b1, 2'd1});
    chainable = 1;
    clear_all();
  endtask

  task automatic t_illegal();
    chainable = 1;
    for (int i = 0; i < NT; i++) setup(i, ldu(4'd0, i < 3), 64'h500);
    acc(1, 64'h500, 0, 0); chk("R9 run of 3 suppressed", 64'(g_hit), 0);
    setup(2, ldu(4'd0, 0), 64'h500);
    acc(1, 64'h500, 0, 0); chk("R9 run of 2 fires", {61'd0, g_hit, g_idx}, {61'd0, 1'b1, 2'd0});
    clear_all();
  endtask

  task automatic t_mte();
    setup(0, mk(4'd2, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0), 64'h600);
    acc(1, 64'h600, 0, 3); chk("R10 M blocked mte0", 64'(g_hit), 0);
    wr(3, 64'h8);
    chk("R10 mte write", {62'd0, mpte, mte}, 64'b01);
    acc(1, 64'h600, 0, 3); chk("R10 M hit mte1", 64'(g_hit), 1);
    @(negedge clk); trap_enter_m = 1; @(negedge clk); trap_enter_m = 0;
    chk("R10 trap save", {62'd0, mpte, mte}, 64'b10);
    acc(1, 64'h600, 0, 3); chk("R10 M blocked after trap", 64'(g_hit), 0);
    @(negedge clk); ret_from_m = 1; @(negedge clk); ret_from_m = 0;
    chk("R10 return restore", 64'(mte), 1);
    acc(1, 64'h600, 0, 3); chk("R10 M hit after return", 64'(g_hit), 1);
    wr(3, 64'h0);
    clear_all();
  endtask

  task automatic t_debug();
    setup(0, ldu(4'd0, 0), 64'h700);
    acc(1, 64'h700, 0, 0); chk("R11 hit outside debug", 64'(g_hit), 1);
    debug_mode = 1;
    acc(1, 64'h700, 0, 0); chk("R11 no hit in debug", 64'(g_hit), 0);
    debug_mode = 0;
    clear_all();
  endtask

  task automatic t_priority();
    setup(1, ldu(4'd0, 0), 64'h800);
    debug_mode = 1;
    setup(3, mk(4'd2, 1, 1, 0, 0, 0, 0, 1, 0, 0, 1, 0), 64'h800);
    debug_mode = 0;
    acc(1, 64'h800, 0, 0);
    chk("R12 lowest wins", {61'd0, g_hit, g_idx}, {61'd0, 1'b1, 2'd1});
    chk("R12 winner action", 64'(g_dbg), 0);
    @(negedge clk); chk("R12 one cycle pulse", 64'(hit_valid), 0);
    wr(0, 64'd1); wr(1, 64'd0);
    acc(1, 64'h800, 0, 0);
    chk("R12 next winner", {61'd0, g_hit, g_idx}, {61'd0, 1'b1, 2'd3});
    chk("R12 debug action", 64'(g_dbg), 1);
    clear_all();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_select();
        t_type();
        t_legal();
        t_action();
        t_compare();
        t_filter();
        t_chain();
        t_illegal();
        t_mte();
        t_debug();
        t_priority();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule